// File: doc/BRIEF.md
# Sleep-State Power Sequencer for a Memory Supply Controller

This block is a clocked state machine that drives the enables of a multi-rail memory power controller. It reads digitized comparator flags: controller supply above its lockout level, main 5 V supply good, and memory rail in regulation. It also reads a system enable and an active-low suspend request. It then moves between five states: off, blanking, sleep (S5), suspend-to-RAM (S3) and run (S0). Its outputs enable a standby 3.3 V regulator, the memory-rail soft-start, a 1.2 V regulator and a termination regulator. It also drives an active-low suspend status and a two-level gate-drive code for a standby power switch.

When the supply flag rises, a blanking window opens and all logic inputs are ignored. The standby regulator turns on two thirds of the way through that window. After blanking, the enable line chooses between sleep and suspend, and the suspend request chooses between suspend and run. Entry to run needs the main supply to be good. The memory rail soft-start starts only after the main supply has been good for a set wait. The 1.2 V and termination regulators follow the memory-rail good flag in run. All delays are cycle counts set by parameters. The enable, suspend-request and main-supply inputs each pass through a synchronizer before use.

Top module: `pwr_state_seq`

## Requirements
- R1: While supply_ok is low, the block is held, without waiting for a clock, in the off state. In that state acpi_state = 0, all four enables are 0, susp_stat_n = 1 and sw_drive = 00.
- R2: After supply_ok rises, acpi_state is blanking (1) after rising edges 1 through BLANK_CYC+1. It is sleep (2) after edge BLANK_CYC+2, whatever en, susp_req_n and main5_ok do during that time.
- R3: During blanking, stby33_en goes high from rising edge (2*BLANK_CYC)/3 + 1 after supply_ok rises and stays high.
- R4: In sleep (2), stby33_en = 1, the other enables are 0, susp_stat_n = 1 and sw_drive = 00. A high synchronized en moves the block to suspend (3).
- R5: A change on en, susp_req_n or main5_ok affects acpi_state on the third rising edge after it is applied, and not before.
- R6: In suspend (3), susp_stat_n = 0, stby33_en = 1, and ldo12_en and vtt_en are 0. sw_drive is 01 (weak pull-down) while the synchronized main5_ok is low and 10 (strong pull-down) while it is high. The code 11 is never driven.
- R7: rail_ss_en is 0 until the block has been in suspend or run with the synchronized main5_ok high for WAIT_CYC+1 rising edges. It then stays 1 while the block remains in suspend or run.
- R8: With susp_req_n high in suspend, the block moves to run (4) only when the synchronized main5_ok is high. Otherwise it stays in suspend.
- R9: In run (4), susp_stat_n = 1, stby33_en = 0 and sw_drive = 00. ldo12_en and vtt_en are both 1 exactly when rail_ss_en and rail_ok are both 1.
- R10: A low susp_req_n in run moves the block to suspend. This turns off ldo12_en and vtt_en, turns stby33_en on, drives susp_stat_n low and keeps rail_ss_en on.
- R11: A low en in suspend or run moves the block to sleep. rail_ss_en, ldo12_en and vtt_en go to 0, and a later start of the rail waits the full WAIT_CYC period again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| supply_ok | input | 1 | Controller supply above lockout; low acts as asynchronous reset |
| main5_ok | input | 1 | Main 5 V supply good flag (synchronized inside) |
| rail_ok | input | 1 | Memory rail in regulation flag |
| en | input | 1 | System enable; low requests sleep (synchronized inside) |
| susp_req_n | input | 1 | Active-low suspend request; high requests run (synchronized inside) |
| stby33_en | output | 1 | Standby 3.3 V regulator enable |
| rail_ss_en | output | 1 | Memory rail soft-start enable |
| ldo12_en | output | 1 | 1.2 V regulator enable |
| vtt_en | output | 1 | Termination regulator enable |
| susp_stat_n | output | 1 | Active-low suspend status |
| sw_drive | output | 2 | Standby switch gate drive: 00 off, 01 weak, 10 strong |
| acpi_state | output | 3 | Current state: 0 off, 1 blanking, 2 sleep, 3 suspend, 4 run |

## Verification
The sequence first holds en high through blanking, which shows that the blanking window ignores its inputs and exits only on its count. Suspend is then entered with the main supply low. This separates the weak from the strong switch drive, and it shows that a pending run request is held off. Raising the main supply next checks the synchronizer latency and the exact edge on which the soft-start wait ends. Toggling rail_ok and the suspend request in both directions separates the 1.2 V and termination gating from the soft-start. A final sleep-and-return round trip confirms that the soft-start wait restarts in full, and dropping supply_ok confirms the asynchronous return to off.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_BLANK = 3'd1,
      ST_SLEEP = 3'd2,
      ST_SUSP  = 3'd3,
      ST_RUN   = 3'd4
   } pstate_t;

   typedef enum logic [1:0] {
      DRV_OFF    = 2'b00,
      DRV_WEAK   = 2'b01,
      DRV_STRONG = 2'b10
   } drv_t;

endpackage

// File: rtl/pwr_sync_chain.sv
module pwr_sync_chain #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwr_sync_chain: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("pwr_sync_chain: WIDTH must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) stg <= '0;
      else         stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pwr_delay_ctr.sv
module pwr_delay_ctr #(
   parameter int LIMIT = 100,
   parameter int W     = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         run,
   output logic [W-1:0] cnt
);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pwr_delay_ctr: LIMIT must be at least 1");
      end
   endgenerate

   localparam logic [W-1:0] CAP = W'(LIMIT);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)          cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt != CAP)  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pwr_out_decode.sv
module pwr_out_decode
   import pwr_seq_pkg::*;
(
   input  pstate_t    st,
   input  logic       stby_early,
   input  logic       ss_on,
   input  logic       main_good,
   input  logic       rail_good,
   output logic       stby33_en,
   output logic       rail_ss_en,
   output logic       ldo12_en,
   output logic       vtt_en,
   output logic       susp_stat_n,
   output logic [1:0] sw_drive
);

   always_comb begin
      stby33_en   = 1'b0;
      rail_ss_en  = 1'b0;
      ldo12_en    = 1'b0;
      vtt_en      = 1'b0;
      susp_stat_n = 1'b1;
      sw_drive    = DRV_OFF;
      unique case (st)
         ST_BLANK: stby33_en = stby_early;
         ST_SLEEP: stby33_en = 1'b1;
         ST_SUSP: begin
            stby33_en   = 1'b1;
            susp_stat_n = 1'b0;
            rail_ss_en  = ss_on;
            sw_drive    = main_good ? DRV_STRONG : DRV_WEAK;
         end
         ST_RUN: begin
            rail_ss_en = ss_on;
            ldo12_en   = ss_on & rail_good;
            vtt_en     = ss_on & rail_good;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
   import pwr_seq_pkg::*;
#(
   parameter int BLANK_CYC   = 3000,
   parameter int WAIT_CYC    = 100,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       supply_ok,
   input  logic       main5_ok,
   input  logic       rail_ok,
   input  logic       en,
   input  logic       susp_req_n,
   output logic       stby33_en,
   output logic       rail_ss_en,
   output logic       ldo12_en,
   output logic       vtt_en,
   output logic       susp_stat_n,
   output logic [1:0] sw_drive,
   output logic [2:0] acpi_state
);

   localparam int STBY_AT = (2 * BLANK_CYC) / 3;
   localparam int BW      = $clog2(BLANK_CYC + 1);
   localparam int WW      = $clog2(WAIT_CYC + 1);

   generate
      if (BLANK_CYC < 3) begin : g_bad_blank
         $error("pwr_state_seq: BLANK_CYC must be at least 3");
      end
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("pwr_state_seq: WAIT_CYC must be at least 1");
      end
   endgenerate

   logic [2:0]    sync_q;
   logic          en_s, run_req_s, main5_s;
   pstate_t       state_q, state_d;
   logic          ss_on_q;
   logic [BW-1:0] blank_cnt;
   logic [WW-1:0] wait_cnt;
   logic          blank_done, stby_early, wait_done, in_rail, wait_run;

   pwr_sync_chain #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (supply_ok),
      .d      ({en, susp_req_n, main5_ok}),
      .q      (sync_q)
   );

   assign en_s      = sync_q[2];
   assign run_req_s = sync_q[1];
   assign main5_s   = sync_q[0];

   assign in_rail  = (state_q == ST_SUSP) || (state_q == ST_RUN);
   assign wait_run = in_rail && main5_s && !ss_on_q;

   pwr_delay_ctr #(.LIMIT(BLANK_CYC), .W(BW)) u_blank (
      .clk    (clk),
      .arst_n (supply_ok),
      .run    (state_q == ST_BLANK),
      .cnt    (blank_cnt)
   );

   pwr_delay_ctr #(.LIMIT(WAIT_CYC), .W(WW)) u_wait (
      .clk    (clk),
      .arst_n (supply_ok),
      .run    (wait_run),
      .cnt    (wait_cnt)
   );

   assign blank_done = (blank_cnt == BW'(BLANK_CYC));
   assign stby_early = (blank_cnt >= BW'(STBY_AT));
   assign wait_done  = (wait_cnt == WW'(WAIT_CYC));

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_OFF:   state_d = ST_BLANK;
         ST_BLANK: if (blank_done) state_d = ST_SLEEP;
         ST_SLEEP: if (en_s) state_d = ST_SUSP;
         ST_SUSP: begin
            if (!en_s)                       state_d = ST_SLEEP;
            else if (run_req_s && main5_s)   state_d = ST_RUN;
         end
         ST_RUN: begin
            if (!en_s)            state_d = ST_SLEEP;
            else if (!run_req_s)  state_d = ST_SUSP;
         end
         default: state_d = ST_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge supply_ok) begin
      if (!supply_ok) begin
         state_q <= ST_OFF;
         ss_on_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (!in_rail)       ss_on_q <= 1'b0;
         else if (wait_done) ss_on_q <= 1'b1;
      end
   end

   pwr_out_decode u_dec (
      .st          (state_q),
      .stby_early  (stby_early),
      .ss_on       (ss_on_q),
      .main_good   (main5_s),
      .rail_good   (rail_ok),
      .stby33_en   (stby33_en),
      .rail_ss_en  (rail_ss_en),
      .ldo12_en    (ldo12_en),
      .vtt_en      (vtt_en),
      .susp_stat_n (susp_stat_n),
      .sw_drive    (sw_drive)
   );

   assign acpi_state = state_q;

endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk
   import pwr_seq_pkg::*;
(
   input logic       clk,
   input logic       supply_ok,
   input logic       rail_ok,
   input logic       main5_s,
   input logic       stby33_en,
   input logic       rail_ss_en,
   input logic       ldo12_en,
   input logic       vtt_en,
   input logic       susp_stat_n,
   input logic [1:0] sw_drive,
   input logic [2:0] acpi_state
);

   assert_off_state_R1: assert property (@(posedge clk)
      !supply_ok |-> (acpi_state == ST_OFF && !stby33_en && !rail_ss_en &&
                      !ldo12_en && !vtt_en && susp_stat_n && sw_drive == DRV_OFF));

   assert_blank_exit_R2: assert property (@(posedge clk) disable iff (!supply_ok)
      acpi_state == ST_BLANK |=> (acpi_state == ST_BLANK || acpi_state == ST_SLEEP));

   assert_sleep_outs_R4: assert property (@(posedge clk) disable iff (!supply_ok)
      acpi_state == ST_SLEEP |-> (stby33_en && !rail_ss_en && !ldo12_en && susp_stat_n));

   assert_susp_status_R6: assert property (@(posedge clk) disable iff (!supply_ok)
      !susp_stat_n |-> (acpi_state == ST_SUSP && stby33_en && !ldo12_en));

   assert_drive_legal_R6: assert property (@(posedge clk) disable iff (!supply_ok)
      sw_drive != 2'b11);

   assert_ss_hold_R7: assert property (@(posedge clk) disable iff (!supply_ok)
      rail_ss_en |=> (rail_ss_en || acpi_state == ST_SLEEP));

   assert_run_gate_R8: assert property (@(posedge clk) disable iff (!supply_ok)
      (acpi_state == ST_RUN && $past(acpi_state) == ST_SUSP) |-> $past(main5_s));

   assert_ldo_pair_R9: assert property (@(posedge clk) disable iff (!supply_ok)
      ldo12_en |-> (vtt_en && rail_ss_en && rail_ok && acpi_state == ST_RUN));

   assert_run_outs_R9: assert property (@(posedge clk) disable iff (!supply_ok)
      acpi_state == ST_RUN |-> (!stby33_en && sw_drive == DRV_OFF && susp_stat_n));

endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (
   .clk         (clk),
   .supply_ok   (supply_ok),
   .rail_ok     (rail_ok),
   .main5_s     (main5_s),
   .stby33_en   (stby33_en),
   .rail_ss_en  (rail_ss_en),
   .ldo12_en    (ldo12_en),
   .vtt_en      (vtt_en),
   .susp_stat_n (susp_stat_n),
   .sw_drive    (sw_drive),
   .acpi_state  (acpi_state)
);

// File: tb/pwr_state_seq_test.sv
`timescale 1ns/1ps
module pwr_state_seq_test;

   localparam int BLANK = 30;
   localparam int WAITC = 10;

   logic clk = 1'b0;
   logic supply_ok = 1'b0, main5_ok = 1'b0, rail_ok = 1'b0, en = 1'b0, susp_req_n = 1'b0;
   logic stby33_en, rail_ss_en, ldo12_en, vtt_en, susp_stat_n;
   logic [1:0] sw_drive;
   logic [2:0] acpi_state;

   int tests = 0;
   int fails = 0;

   typedef struct {
      string      tag;
      logic [9:0] v;
   } exp_t;
   exp_t exq[$];

   always #4 clk = ~clk;

   pwr_state_seq #(.BLANK_CYC(BLANK), .WAIT_CYC(WAITC), .SYNC_STAGES(2)) uut (
      .clk (clk), .supply_ok (supply_ok), .main5_ok (main5_ok), .rail_ok (rail_ok),
      .en (en), .susp_req_n (susp_req_n), .stby33_en (stby33_en), .rail_ss_en (rail_ss_en),
      .ldo12_en (ldo12_en), .vtt_en (vtt_en), .susp_stat_n (susp_stat_n),
      .sw_drive (sw_drive), .acpi_state (acpi_state)
   );

   // vector: {stby, ss, ldo12, vtt, stat_n, drive[1:0], state[2:0]}
   function automatic logic [9:0] mk(logic [2:0] st, logic sb, logic ss, logic l12,
                                     logic stn, logic [1:0] dr);
      return {sb, ss, l12, l12, stn, dr, st};
   endfunction

   task automatic push_exp(string tag, logic [9:0] v);
      exq.push_back('{tag: tag, v: v});
      #2;
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (exq.size() > 0) begin
            exp_t e;
            logic [9:0] act;
            e = exq.pop_front();
            act = {stby33_en, rail_ss_en, ldo12_en, vtt_en, susp_stat_n, sw_drive, acpi_state};
            tests++;
            if (act !== e.v) begin
               fails++;
               $display("FAIL %s: actual %b expected %b", e.tag, act, e.v);
            end
            tests++;
            if (sw_drive === 2'b11) begin
               fails++;
               $display("FAIL R6 (drive code): actual %b expected not 11", sw_drive);
            end
         end
      end
   end

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      step(2);
      push_exp("R1 held off", mk(3'd0, 0, 0, 0, 1, 2'b00));

      supply_ok = 1'b1; en = 1'b1; susp_req_n = 1'b1;
      step(20);
      push_exp("R3 standby still off at edge 20", mk(3'd1, 0, 0, 0, 1, 2'b00));
      step(1);
      push_exp("R3 standby on at edge 21", mk(3'd1, 1, 0, 0, 1, 2'b00));
      step(10);
      push_exp("R2 blanking ignores en at edge 31", mk(3'd1, 1, 0, 0, 1, 2'b00));
      step(1);
      push_exp("R2 R4 sleep at edge 32", mk(3'd2, 1, 0, 0, 1, 2'b00));
      step(1);
      push_exp("R4 R6 suspend weak drive", mk(3'd3, 1, 0, 0, 0, 2'b01));
      step(20);
      push_exp("R7 R8 run held without main", mk(3'd3, 1, 0, 0, 0, 2'b01));

      main5_ok = 1'b1;
      step(2);
      push_exp("R5 R6 still suspend, strong drive", mk(3'd3, 1, 0, 0, 0, 2'b10));
      step(1);
      push_exp("R5 R8 R9 run on third edge", mk(3'd4, 0, 0, 0, 1, 2'b00));
      step(9);
      push_exp("R7 soft-start still off", mk(3'd4, 0, 0, 0, 1, 2'b00));
      step(1);
      push_exp("R7 R9 soft-start on, rail not good", mk(3'd4, 0, 1, 0, 1, 2'b00));

      rail_ok = 1'b1;
      step(1);
      push_exp("R9 ldos follow rail_ok", mk(3'd4, 0, 1, 1, 1, 2'b00));

      susp_req_n = 1'b0;
      step(2);
      push_exp("R5 run before sync completes", mk(3'd4, 0, 1, 1, 1, 2'b00));
      step(1);
      push_exp("R10 suspend from run", mk(3'd3, 1, 1, 0, 0, 2'b10));

      susp_req_n = 1'b1;
      step(3);
      push_exp("R9 back to run", mk(3'd4, 0, 1, 1, 1, 2'b00));

      en = 1'b0;
      step(3);
      push_exp("R11 sleep clears rail", mk(3'd2, 1, 0, 0, 1, 2'b00));

      en = 1'b1;
      step(3);
      push_exp("R6 suspend entry strong drive", mk(3'd3, 1, 0, 0, 0, 2'b10));
      step(1);
      push_exp("R8 run with main good", mk(3'd4, 0, 0, 0, 1, 2'b00));
      step(9);
      push_exp("R11 R7 wait restarts in full", mk(3'd4, 0, 0, 0, 1, 2'b00));
      step(1);
      push_exp("R7 soft-start after full wait", mk(3'd4, 0, 1, 1, 1, 2'b00));

      supply_ok = 1'b0;
      push_exp("R1 async return to off", mk(3'd0, 0, 0, 0, 1, 2'b00));

      step(2);
      summary();
      $finish;
   end

endmodule